// File: doc/BRIEF.md
# Source-Routed Hop Port Selection

This block holds both halves of a source-routing scheme for an on-chip network. On the injection side it maps a request address to a destination endpoint number through a small set of address rules. It then looks up the precomputed path to that endpoint in a route table, which arrives on an input port. The destination number, the path and a decode-error flag are captured into a header register in the same cycle that the request is presented.

On the router side, a combinational hop decoder reads the lowest group of path bits and uses them as the output-port number. It passes on the path shifted down by one group, so the next router finds its own bits at the bottom. A port number equal to the local ejection port means the packet has arrived. The path is therefore fixed entirely at injection, and routers compute nothing from coordinates.

Each group is `HOP_W = ceil(log2(NUM_PORTS))` bits wide, and the path field holds `MAX_HOPS` such groups. With the defaults (5 ports, 4 hops, 4 endpoints, 16-bit addresses, 4 rules) that gives 3-bit groups and a 12-bit path.

Top module: `srt_route_top`

## Requirements
- R1: While `rst` is high at a clock edge, `hdr_valid_o`, `hdr_dst_o`, `hdr_route_o` and `hdr_err_o` are all zero after that edge.
- R2: Rule k matches when `base_k <= addr < limit_k`. Rule k's base, limit and endpoint are slice k of `rule_base_i`, `rule_limit_i` and `rule_dst_i`, and slice k occupies bits [k*W +: W]. When several rules match, the lowest-numbered one sets the captured destination. A rule with `limit <= base` never matches.
- R3: The captured path equals the `ROUTE_W`-bit slice of `route_tbl_i` at index (destination × `ROUTE_W`), taken from the table value present at the capture edge. A table change is reflected in the next capture.
- R4: When no rule matches, the captured `hdr_err_o` is 1, the destination is `DEFAULT_DST` (0), and the path is that endpoint's table entry. On a match, `hdr_err_o` is 0.
- R5: A request sampled with `inj_valid_i` high at a clock edge shows up on the header outputs after that edge. `hdr_valid_o` is high for exactly the cycles after edges at which `inj_valid_i` was high.
- R6: At an edge where `inj_valid_i` is low, the header destination, path and error flag keep their values, whatever the address inputs carry.
- R7: `hop_port_o` equals bits [HOP_W-1:0] of `hop_route_i`, combinationally.
- R8: `hop_route_o` equals `hop_route_i` shifted right by `HOP_W`, with zeros entering the top `HOP_W` bits.
- R9: `hop_eject_o` is 1 exactly when `hop_port_o` equals `LOCAL_PORT` (0).
- R10: Feeding `hop_route_o` back as `hop_route_i` `MAX_HOPS` times yields the packed port groups in order, lowest group first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid_i | input | 1 | Request present, capture header |
| inj_addr_i | input | ADDR_W | Request address |
| rule_base_i | input | NUM_RULES*ADDR_W | Inclusive lower bound per rule |
| rule_limit_i | input | NUM_RULES*ADDR_W | Exclusive upper bound per rule |
| rule_dst_i | input | NUM_RULES*DST_W | Endpoint per rule |
| route_tbl_i | input | NUM_DST*ROUTE_W | Path per endpoint |
| hdr_valid_o | output | 1 | Header register holds a new request |
| hdr_dst_o | output | DST_W | Captured destination endpoint |
| hdr_route_o | output | ROUTE_W | Captured path field |
| hdr_err_o | output | 1 | Captured address miss flag |
| hop_route_i | input | ROUTE_W | Path field arriving at a router |
| hop_port_o | output | HOP_W | Selected output port |
| hop_route_o | output | ROUTE_W | Path field forwarded to the next hop |
| hop_eject_o | output | 1 | Selected port is the local ejection port |

## Verification
Header results appear one edge after the request is sampled. The bench therefore drives each request on a falling edge and compares the header on the next falling edge, after exactly one rising edge. The hop decoder has no register, so its outputs are compared a fixed delay after `hop_route_i` changes, with no clock involved. The bench sweeps every possible path value, every multi-hop port sequence and a stepped address range that covers all rule boundaries and overlaps. Table swaps and idle cycles are checked with the same one-edge timing.

// File: rtl/srt_pkg.sv
package srt_pkg;

    // number of bits needed to name n distinct values (at least 1)
    function automatic int unsigned bits_for(input int unsigned n);
        int unsigned b;
        b = 1;
        while ((1 << b) < n) b++;
        return b;
    endfunction

    // router-side hop decode result
    typedef enum logic [0:0] {
        HOP_FORWARD = 1'b0,
        HOP_ARRIVED = 1'b1
    } hop_kind_e;

endpackage

// File: rtl/srt_addr_decode.sv
module srt_addr_decode #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned NUM_RULES   = 4,
    parameter int unsigned DST_W       = 2,
    parameter int unsigned DEFAULT_DST = 0
) (
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [NUM_RULES*ADDR_W-1:0] base_i,
    input  logic [NUM_RULES*ADDR_W-1:0] limit_i,
    input  logic [NUM_RULES*DST_W-1:0]  dst_i,
    output logic [DST_W-1:0]            dst_o,
    output logic                        miss_o
);

    logic [NUM_RULES-1:0] hit;

    generate
        for (genvar k = 0; k < NUM_RULES; k++) begin : g_rule
            assign hit[k] = (addr_i >= base_i[k*ADDR_W +: ADDR_W]) &&
                            (addr_i <  limit_i[k*ADDR_W +: ADDR_W]);
        end
    endgenerate

    // walk from the highest index down so the lowest hit wins
    always_comb begin
        dst_o  = DST_W'(DEFAULT_DST);
        miss_o = 1'b1;
        for (int k = NUM_RULES - 1; k >= 0; k--) begin
            if (hit[k]) begin
                dst_o  = dst_i[k*DST_W +: DST_W];
                miss_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/srt_route_lookup.sv
module srt_route_lookup #(
    parameter int unsigned NUM_DST = 4,
    parameter int unsigned DST_W   = 2,
    parameter int unsigned ROUTE_W = 12
) (
    input  logic [DST_W-1:0]           dst_i,
    input  logic [NUM_DST*ROUTE_W-1:0] tbl_i,
    output logic [ROUTE_W-1:0]         route_o
);

    always_comb begin
        route_o = '0;
        for (int d = 0; d < NUM_DST; d++) begin
            if (dst_i == DST_W'(d)) route_o = tbl_i[d*ROUTE_W +: ROUTE_W];
        end
    end

endmodule

// File: rtl/srt_hop_decode.sv
module srt_hop_decode
    import srt_pkg::*;
#(
    parameter int unsigned HOP_W      = 3,
    parameter int unsigned ROUTE_W    = 12,
    parameter int unsigned LOCAL_PORT = 0
) (
    input  logic [ROUTE_W-1:0] route_i,
    output logic [HOP_W-1:0]   port_o,
    output logic [ROUTE_W-1:0] route_o,
    output hop_kind_e          kind_o
);

    assign port_o  = route_i[HOP_W-1:0];
    assign route_o = {{HOP_W{1'b0}}, route_i[ROUTE_W-1:HOP_W]};
    assign kind_o  = (port_o == HOP_W'(LOCAL_PORT)) ? HOP_ARRIVED : HOP_FORWARD;

endmodule

// File: rtl/srt_route_top.sv
module srt_route_top
    import srt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned NUM_RULES   = 4,
    parameter int unsigned NUM_DST     = 4,
    parameter int unsigned NUM_PORTS   = 5,
    parameter int unsigned MAX_HOPS    = 4,
    parameter int unsigned LOCAL_PORT  = 0,
    parameter int unsigned DEFAULT_DST = 0,
    localparam int unsigned DST_W      = bits_for(NUM_DST),
    localparam int unsigned HOP_W      = bits_for(NUM_PORTS),
    localparam int unsigned ROUTE_W    = HOP_W * MAX_HOPS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        inj_valid_i,
    input  logic [ADDR_W-1:0]           inj_addr_i,
    input  logic [NUM_RULES*ADDR_W-1:0] rule_base_i,
    input  logic [NUM_RULES*ADDR_W-1:0] rule_limit_i,
    input  logic [NUM_RULES*DST_W-1:0]  rule_dst_i,
    input  logic [NUM_DST*ROUTE_W-1:0]  route_tbl_i,
    output logic                        hdr_valid_o,
    output logic [DST_W-1:0]            hdr_dst_o,
    output logic [ROUTE_W-1:0]          hdr_route_o,
    output logic                        hdr_err_o,
    input  logic [ROUTE_W-1:0]          hop_route_i,
    output logic [HOP_W-1:0]            hop_port_o,
    output logic [ROUTE_W-1:0]          hop_route_o,
    output logic                        hop_eject_o
);

    typedef struct packed {
        logic               valid;
        logic [DST_W-1:0]   dst;
        logic [ROUTE_W-1:0] route;
        logic               err;
    } hdr_t;

    logic [DST_W-1:0]   dec_dst;
    logic               dec_miss;
    logic [ROUTE_W-1:0] lut_route;
    hop_kind_e          hop_kind;
    hdr_t               hdr_q;

    srt_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES),
        .DST_W(DST_W), .DEFAULT_DST(DEFAULT_DST)
    ) u_dec (
        .addr_i (inj_addr_i),
        .base_i (rule_base_i),
        .limit_i(rule_limit_i),
        .dst_i  (rule_dst_i),
        .dst_o  (dec_dst),
        .miss_o (dec_miss)
    );

    srt_route_lookup #(
        .NUM_DST(NUM_DST), .DST_W(DST_W), .ROUTE_W(ROUTE_W)
    ) u_lut (
        .dst_i  (dec_dst),
        .tbl_i  (route_tbl_i),
        .route_o(lut_route)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
        end else begin
            hdr_q.valid <= inj_valid_i;
            if (inj_valid_i) begin
                hdr_q.dst   <= dec_dst;
                hdr_q.route <= lut_route;
                hdr_q.err   <= dec_miss;
            end
        end
    end

    assign hdr_valid_o = hdr_q.valid;
    assign hdr_dst_o   = hdr_q.dst;
    assign hdr_route_o = hdr_q.route;
    assign hdr_err_o   = hdr_q.err;

    srt_hop_decode #(
        .HOP_W(HOP_W), .ROUTE_W(ROUTE_W), .LOCAL_PORT(LOCAL_PORT)
    ) u_hop (
        .route_i(hop_route_i),
        .port_o (hop_port_o),
        .route_o(hop_route_o),
        .kind_o (hop_kind)
    );

    assign hop_eject_o = (hop_kind == HOP_ARRIVED);

endmodule

// File: rtl/srt_route_chk.sv
module srt_route_chk #(
    parameter int unsigned NUM_DST     = 4,
    parameter int unsigned DST_W       = 2,
    parameter int unsigned HOP_W       = 3,
    parameter int unsigned ROUTE_W     = 12,
    parameter int unsigned LOCAL_PORT  = 0,
    parameter int unsigned DEFAULT_DST = 0
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       inj_valid_i,
    input logic [NUM_DST*ROUTE_W-1:0] route_tbl_i,
    input logic                       hdr_valid_o,
    input logic [DST_W-1:0]           hdr_dst_o,
    input logic [ROUTE_W-1:0]         hdr_route_o,
    input logic                       hdr_err_o,
    input logic [HOP_W-1:0]           hop_port_o,
    input logic [ROUTE_W-1:0]         hop_route_o,
    input logic                       hop_eject_o
);

    logic [NUM_DST*ROUTE_W-1:0] tbl_q;
    always_ff @(posedge clk) tbl_q <= route_tbl_i;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!hdr_valid_o && hdr_dst_o == '0 && hdr_route_o == '0 && !hdr_err_o));

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        inj_valid_i |=> hdr_valid_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inj_valid_i |=> ($stable(hdr_dst_o) && $stable(hdr_route_o) && $stable(hdr_err_o)));

    // R3
    route_match_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_valid_o |-> hdr_route_o == tbl_q[int'(hdr_dst_o)*ROUTE_W +: ROUTE_W]);

    // R4
    miss_default_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_err_o |-> hdr_dst_o == DST_W'(DEFAULT_DST));

    // R8
    shift_fill_chk: assert property (@(posedge clk) disable iff (rst)
        hop_route_o[ROUTE_W-1 -: HOP_W] == '0);

    // R9
    eject_port_chk: assert property (@(posedge clk) disable iff (rst)
        hop_eject_o |-> hop_port_o == HOP_W'(LOCAL_PORT));

endmodule

bind srt_route_top srt_route_chk #(
    .NUM_DST(NUM_DST), .DST_W(DST_W), .HOP_W(HOP_W), .ROUTE_W(ROUTE_W),
    .LOCAL_PORT(LOCAL_PORT), .DEFAULT_DST(DEFAULT_DST)
) u_chk (
    .clk(clk), .rst(rst), .inj_valid_i(inj_valid_i), .route_tbl_i(route_tbl_i),
    .hdr_valid_o(hdr_valid_o), .hdr_dst_o(hdr_dst_o), .hdr_route_o(hdr_route_o),
    .hdr_err_o(hdr_err_o), .hop_port_o(hop_port_o), .hop_route_o(hop_route_o),
    .hop_eject_o(hop_eject_o)
);

// File: tb/sim_srt_route_top.sv
`timescale 1ns/1ps
module sim_srt_route_top;

    localparam int AW = 16;
    localparam int NR = 4;
    localparam int ND = 4;
    localparam int DW = 2;
    localparam int HW = 3;
    localparam int MH = 4;
    localparam int RW = HW * MH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inj_valid_i = 1'b0;
    logic [AW-1:0] inj_addr_i = '0;
    logic [NR*AW-1:0] rule_base_i, rule_limit_i;
    logic [NR*DW-1:0] rule_dst_i;
    logic [ND*RW-1:0] route_tbl_i;
    logic hdr_valid_o, hdr_err_o, hop_eject_o;
    logic [DW-1:0] hdr_dst_o;
    logic [RW-1:0] hdr_route_o, hop_route_o;
    logic [RW-1:0] hop_route_i = '0;
    logic [HW-1:0] hop_port_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    srt_route_top u0 (
        .clk(clk), .rst(rst), .inj_valid_i(inj_valid_i), .inj_addr_i(inj_addr_i),
        .rule_base_i(rule_base_i), .rule_limit_i(rule_limit_i), .rule_dst_i(rule_dst_i),
        .route_tbl_i(route_tbl_i), .hdr_valid_o(hdr_valid_o), .hdr_dst_o(hdr_dst_o),
        .hdr_route_o(hdr_route_o), .hdr_err_o(hdr_err_o), .hop_route_i(hop_route_i),
        .hop_port_o(hop_port_o), .hop_route_o(hop_route_o), .hop_eject_o(hop_eject_o)
    );

    int bases  [NR] = '{16'h1000, 16'h1800, 16'h8000, 16'h5000};
    int limits [NR] = '{16'h2000, 16'h4000, 16'h9000, 16'h5000};
    int dsts   [NR] = '{1, 2, 3, 1};
    int salt = 5;

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int tbl_entry(input int d);
        return ((d * 1237 + salt * 401) & ((1 << RW) - 1));
    endfunction

    task automatic load_table();
        for (int d = 0; d < ND; d++) route_tbl_i[d*RW +: RW] = RW'(tbl_entry(d));
    endtask

    // model of the rule set: first hit in index order, else default 0
    task automatic model(input int a, output int d, output int err);
        d = 0; err = 1;
        for (int k = NR - 1; k >= 0; k--)
            if (a >= bases[k] && a < limits[k]) begin d = dsts[k]; err = 0; end
    endtask

    task automatic inject_check(input int a);
        int d, e;
        model(a, d, e);
        inj_addr_i  = AW'(a);
        inj_valid_i = 1'b1;
        @(negedge clk);
        check("R5 valid", hdr_valid_o, 1);
        check("R2 dst", hdr_dst_o, d);
        check("R4 err", hdr_err_o, e);
        check("R3 route", hdr_route_o, tbl_entry(d));
    endtask

    initial begin
        for (int k = 0; k < NR; k++) begin
            rule_base_i[k*AW +: AW]  = AW'(bases[k]);
            rule_limit_i[k*AW +: AW] = AW'(limits[k]);
            rule_dst_i[k*DW +: DW]   = DW'(dsts[k]);
        end
        load_table();
        inj_addr_i = 16'h1234;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", hdr_valid_o, 0);
        check("R1 dst", hdr_dst_o, 0);
        check("R1 route", hdr_route_o, 0);
        check("R1 err", hdr_err_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R5 idle valid", hdr_valid_o, 0);

        // R2 R4 stepped address sweep plus every boundary
        for (int a = 0; a < 65536; a += 97) inject_check(a);
        for (int k = 0; k < NR; k++) begin
            inject_check(bases[k]); inject_check(bases[k] - 1);
            inject_check(limits[k]); inject_check(limits[k] - 1);
        end
        inject_check(16'h1900);   // R2 overlap: rule 0 wins
        inject_check(16'hFFFF);   // R4 miss

        // R6 hold while idle with a different address
        inject_check(16'h8100);
        inj_valid_i = 1'b0;
        inj_addr_i  = 16'h1100;
        @(negedge clk);
        check("R5 drop valid", hdr_valid_o, 0);
        check("R6 hold dst", hdr_dst_o, 3);
        check("R6 hold route", hdr_route_o, tbl_entry(3));
        check("R6 hold err", hdr_err_o, 0);

        // R3 table swap reflected on next capture
        salt = 9;
        load_table();
        for (int a = 0; a < 65536; a += 4099) inject_check(a);
        inj_valid_i = 1'b0;

        // R7 R8 R9 every path value
        for (int r = 0; r < (1 << RW); r++) begin
            hop_route_i = RW'(r);
            #1;
            check("R7 port", hop_port_o, r % (1 << HW));
            check("R8 shift", hop_route_o, r / (1 << HW));
            check("R9 eject", hop_eject_o, (r % (1 << HW)) == 0);
        end

        // R10 multi-hop walk over all in-range port sequences
        for (int s = 0; s < 625; s++) begin
            int p [MH];
            int v, t;
            v = 0; t = s;
            for (int h = 0; h < MH; h++) begin p[h] = t % 5; t = t / 5; end
            for (int h = MH - 1; h >= 0; h--) v = v * (1 << HW) + p[h];
            hop_route_i = RW'(v);
            for (int h = 0; h < MH; h++) begin
                #1;
                check("R10 walk port", hop_port_o, p[h]);
                hop_route_i = hop_route_o;
            end
            #1;
            check("R10 drained", hop_route_i, 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule